// File: doc/BRIEF.md
# Register-Programmed I2C Bus Master

This block is an I2C master driven through four byte-wide registers: a data buffer, a control byte, a status byte and a clock divider. After reset it stays passive on the bus and behaves as an idle receiver. Software places the 7-bit target address and the read/write flag in the data buffer. It then sets the start and go bits in the control byte, and the block runs the START condition and shifts out the address byte. Every later byte needs a new go bit. Software can ask for a STOP after any byte.

The block drives SCL and SDA as open-drain signals: an `_oe` output high pulls the line low. It reads the wired bus back on `scl_in` and `sda_in`. While the block is sending a one, it compares SDA with its own output. If another master pulls the line low, the block stops driving SDA but clocks on to the end of the byte, then flags the loss. If the loss happened in the address byte, the block waits for a STOP on the bus and sends START and the address again by itself. The go bit clears itself when a byte finishes, and a completion flag can raise an interrupt.

Top module: `i2c_reg_master`

## Requirements
- R1: After reset, the control byte and status byte read 0. The divider reads its parameter default. `scl_oe`, `sda_oe` and `irq` are 0.
- R2: SCL is driven only when control bit 6 (unit enable) and bit 5 (clock enable) are both 1. With clock enable at 0, a start+go request produces no bus activity and the status busy bit (bit 3) stays 0.
- R3: Control bit 1 (start) together with bit 0 (go) produces a START. The next byte on the bus is data buffer bits 7..1, most significant bit first, followed by data buffer bit 0 as the direction bit.
- R4: At the end of each byte plus its acknowledge bit, the block clears go (control bit 0) and sets status bit 0 (done). `irq` equals status bit 0 AND control bit 4 (interrupt enable). Writing a control byte with go=1 clears status bit 0.
- R5: In transmit mode, a go write shifts the data buffer out in eight bits, most significant bit first. SDA only changes while SCL is low. If control bit 2 (stop) was set, a STOP follows, and status bit 3 returns to 0 once the STOP is complete.
- R6: If the addressed device does not acknowledge a byte, status bit 2 (acknowledge error) is set.
- R7: After an address byte whose direction bit is 1, the block becomes a receiver and status bit 5 reads 1. Each go then clocks in one byte, and the received byte is readable from the data buffer. After the byte the block sends ACK when control bit 3 is 0 and NACK when it is 1.
- R8: Arbitration is lost when SDA reads low while the block is releasing it for a one bit. The block stops driving SDA, finishes the byte and sets status bit 1. If this happens in a data byte, the block clears go and returns to idle with both lines released.
- R9: On an arbitration loss in the address byte, the block keeps go set and both lines released until a STOP appears on the bus. It then repeats the START and address by itself and completes the byte.
- R10: With divider value D (register 3), each SCL low interval and each SCL high interval lasts 2*(D+1) clock cycles.
- R11: Writing 1 to status bits 0, 1 or 2 clears that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 data, 1 control, 2 status, 3 divider |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| scl_in | input | 1 | Sampled SCL bus level |
| sda_in | input | 1 | Sampled SDA bus level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| irq | output | 1 | Byte-completion interrupt request |

## Verification
The bench builds the block with DIV_W=6 and DIV_INIT=3. At those values the reset value of the divider can be read back, and a byte lasts only about 150 cycles, so a full transaction, a lost arbitration and an address retry fit in a short run. The divider is reprogrammed to 1 before the receive test, which checks R10 at a second point. An open-drain bus model connects a responding target and a second bus driver. The second driver pulls SDA low in chosen bit slots to force arbitration loss in both the address and the data phase.

// File: rtl/i2c_reg_master.sv
module i2c_reg_master #(
  parameter int DIV_W    = 8,
  parameter int DIV_INIT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       irq
);
  localparam logic [2:0] S_IDLE = 3'd0, S_START = 3'd1, S_BIT = 3'd2,
                         S_HOLD = 3'd3, S_STOP = 3'd4, S_WAIT = 3'd5;

  logic [7:0] data_q, sh;
  logic go_q, sta_q, sto_q, ackn_q, ien_q, sen_q, uen_q;
  logic done_q, arb_q, aerr_q;
  logic [DIV_W-1:0] div_q, cnt;
  logic [2:0] st;
  logic [1:0] ph;
  logic [3:0] bitn;
  logic lost, is_addr, rxm, rw_q, stop_req, nack_q;
  logic scl_q, sda_q, sda_prev, scl_prev, bus_busy;

  wire en     = uen_q & sen_q;
  wire tick   = (cnt >= div_q);
  wire txm    = is_addr | ~rxm;
  wire busy_m = (st != S_IDLE);
  wire start_det = scl_in & scl_prev & sda_prev & ~sda_in;
  wire stop_det  = scl_in & scl_prev & ~sda_prev & sda_in;

  assign scl_oe = scl_q & en;
  assign sda_oe = sda_q & uen_q;
  assign irq    = done_q & ien_q;

  always_comb
    case (reg_addr)
      2'd0:    reg_rdata = data_q;
      2'd1:    reg_rdata = {1'b0, uen_q, sen_q, ien_q, ackn_q, sto_q, sta_q, go_q};
      2'd2:    reg_rdata = {2'b0, rxm, bus_busy, busy_m, aerr_q, arb_q, done_q};
      default: reg_rdata = 8'(div_q);
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      data_q <= '0; sh <= '0;
      {go_q, sta_q, sto_q, ackn_q, ien_q, sen_q, uen_q} <= '0;
      {done_q, arb_q, aerr_q} <= '0;
      div_q <= DIV_W'(DIV_INIT); cnt <= '0;
      st <= S_IDLE; ph <= '0; bitn <= '0;
      {lost, is_addr, rxm, rw_q, stop_req, nack_q} <= '0;
      {scl_q, sda_q} <= '0;
      sda_prev <= 1'b1; scl_prev <= 1'b1; bus_busy <= 1'b0;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      sda_prev <= sda_in;
      scl_prev <= scl_in;
      if (start_det) bus_busy <= 1'b1;
      else if (stop_det) bus_busy <= 1'b0;

      if (reg_wr)
        case (reg_addr)
          2'd0: data_q <= reg_wdata;
          2'd1: begin
            {uen_q, sen_q, ien_q, ackn_q, sto_q, sta_q, go_q} <= reg_wdata[6:0];
            if (reg_wdata[0]) done_q <= 1'b0;
          end
          2'd2: begin
            if (reg_wdata[0]) done_q <= 1'b0;
            if (reg_wdata[1]) arb_q  <= 1'b0;
            if (reg_wdata[2]) aerr_q <= 1'b0;
          end
          default: div_q <= reg_wdata[DIV_W-1:0];
        endcase

      case (st)
        S_IDLE, S_WAIT: begin
          scl_q <= 1'b0; sda_q <= 1'b0;
          if (go_q && en && !bus_busy && (st == S_WAIT || sta_q)) begin
            sh <= data_q; rw_q <= data_q[0]; stop_req <= sto_q;
            is_addr <= 1'b1; rxm <= 1'b0; lost <= 1'b0; nack_q <= 1'b0;
            st <= S_START; ph <= '0;
          end
        end
        S_START: if (tick) begin
          ph <= ph + 2'd1;
          case (ph)
            2'd0: sda_q <= 1'b0;
            2'd1: scl_q <= 1'b0;
            2'd2: sda_q <= 1'b1;
            default: begin scl_q <= 1'b1; st <= S_BIT; bitn <= '0; end
          endcase
        end
        S_BIT: if (tick) begin
          ph <= ph + 2'd1;
          case (ph)
            2'd0: if (bitn == 4'd8) sda_q <= txm ? 1'b0 : ~ackn_q;
                  else sda_q <= txm & ~lost & ~sh[7];
            2'd1: scl_q <= 1'b0;
            2'd2: if (bitn < 4'd8) begin
                    sh <= {sh[6:0], sda_in};
                    if (txm && !lost && sh[7] && !sda_in) lost <= 1'b1;
                  end else nack_q <= sda_in;
            default:
              if (bitn == 4'd7 && lost) begin
                scl_q <= 1'b0; sda_q <= 1'b0; arb_q <= 1'b1;
                if (is_addr) st <= S_WAIT;
                else begin st <= S_IDLE; go_q <= 1'b0; end
              end else if (bitn == 4'd8) begin
                scl_q <= 1'b1; go_q <= 1'b0; done_q <= 1'b1; is_addr <= 1'b0;
                if (is_addr) rxm <= rw_q;
                if (!txm) data_q <= sh;
                if (txm && nack_q) aerr_q <= 1'b1;
                st <= stop_req ? S_STOP : S_HOLD;
              end else begin
                scl_q <= 1'b1; bitn <= bitn + 4'd1;
              end
          endcase
        end
        S_HOLD: if (go_q) begin
          sh <= data_q; stop_req <= sto_q; lost <= 1'b0; nack_q <= 1'b0;
          bitn <= '0; ph <= '0;
          if (sta_q) begin
            is_addr <= 1'b1; rxm <= 1'b0; rw_q <= data_q[0]; st <= S_START;
          end else st <= S_BIT;
        end
        S_STOP: if (tick) begin
          ph <= ph + 2'd1;
          case (ph)
            2'd0: sda_q <= 1'b1;
            2'd1: scl_q <= 1'b0;
            2'd2: sda_q <= 1'b0;
            default: st <= S_IDLE;
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
endmodule

// File: rtl/i2c_reg_master_chk.sv
module i2c_reg_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       irq,
  input logic       scl_in,
  input logic       go,
  input logic       done,
  input logic       lost,
  input logic       en,
  input logic [2:0] st
);
  localparam logic [2:0] C_BIT = 3'd2, C_WAIT = 3'd5;

  p_scl_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !scl_oe);

  p_irq_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done);

  p_done_go_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !go);

  p_sda_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_BIT && $past(st) == C_BIT && scl_in && $past(scl_in)) |-> $stable(sda_oe));

  p_lost_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lost |-> !sda_oe);

  p_wait_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_WAIT && $past(st) == C_WAIT) |-> (!scl_oe && !sda_oe && go));
endmodule

bind i2c_reg_master i2c_reg_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq),
  .scl_in(scl_in), .go(go_q), .done(done_q), .lost(lost), .en(en), .st(st)
);

// File: tb/test_i2c_reg_master.sv
`timescale 1ns/1ps
module test_i2c_reg_master;
  localparam logic [6:0] TGT = 7'h2A;
  localparam int GO = 1, STA = 2, STO = 4, ACKN = 8, IEN = 16, EN = 96;

  logic clk = 0, rst_n = 0;
  logic [1:0] reg_addr = 0;
  logic reg_wr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic scl_oe, sda_oe, irq;
  logic sl = 0, rogue = 0;
  logic bus_scl, bus_sda;
  int checks = 0, errors = 0;
  bit finished = 0;

  assign bus_scl = ~scl_oe;
  assign bus_sda = ~(sda_oe | sl | rogue);

  always #2.5 clk = ~clk;

  i2c_reg_master #(.DIV_W(6), .DIV_INIT(3)) i_i2c_reg_master (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_in(bus_scl),
    .sda_in(bus_sda), .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq));

  // responding target
  int bit_i = 9, byte_i = 0, starts = 0, stops = 0;
  logic [7:0] shreg = 0;
  logic [7:0] log_b [0:3];
  logic [7:0] rdbuf [0:3];
  logic rd = 0, mack = 1, nack_data = 0;

  always @(negedge bus_sda) if (bus_scl === 1'b1) begin
    starts++; bit_i = -1; byte_i = 0; rd = 0;
  end
  always @(posedge bus_sda) if (bus_scl === 1'b1) stops++;
  always @(posedge bus_scl) begin
    if (bit_i >= 0 && bit_i < 8) shreg = {shreg[6:0], bus_sda};
    else if (bit_i == 8) mack = bus_sda;
  end
  always @(negedge bus_scl) begin
    if (bit_i == 8) begin
      sl = 0; bit_i = 0;
      byte_i++;
      if (rd && !mack && byte_i < 4) sl = ~rdbuf[byte_i][7];
    end else if (bit_i < 8) begin
      bit_i++;
      if (bit_i == 8) begin
        if (byte_i < 4) log_b[byte_i] = shreg;
        if (byte_i == 0) begin
          sl = (shreg[7:1] == TGT);
          rd = (shreg[7:1] == TGT) && shreg[0];
        end else if (rd) sl = 0;
        else sl = ~nack_data;
      end else if (rd && byte_i > 0 && byte_i < 4) sl = ~rdbuf[byte_i][7-bit_i];
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); reg_addr = 2'(a); reg_wdata = 8'(d); reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rdr(int a, output int d);
    @(negedge clk); reg_addr = 2'(a); #1 d = int'(reg_rdata);
  endtask

  task automatic wait_stat(int mask, int val);
    int s;
    for (int i = 0; i < 3000; i++) begin
      rdr(2, s);
      if ((s & mask) == val) break;
    end
  endtask

  task automatic rogue_stop();
    #20 rogue = 1; #40 rogue = 0; #40;
  endtask

  task automatic t_reset();
    int v;
    rdr(1, v); chk("R1 ctl", v, 0);
    rdr(2, v); chk("R1 status", v, 0);
    rdr(3, v); chk("R1 divider", v, 3);
    chk("R1 lines", {scl_oe, sda_oe, irq}, 0);
  endtask

  task automatic t_disabled();
    int bad = 0, v;
    wr(0, 8'h54);
    wr(1, 64 | STA | GO);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (scl_oe || sda_oe) bad++;
    end
    chk("R2 no bus activity", bad, 0);
    rdr(2, v); chk("R2 busy bit", (v >> 3) & 1, 0);
    wr(1, 0);
  endtask

  task automatic t_write();
    int v, s0, p0;
    realtime ta, tb, tc;
    s0 = starts; p0 = stops;
    wr(0, 8'h54);
    wr(1, EN | IEN | STA | GO);
    wait_stat(1, 1);
    chk("R3 start seen", starts - s0, 1);
    chk("R3 address byte", log_b[0], 8'h54);
    rdr(1, v); chk("R4 go cleared", v & 1, 0);
    rdr(2, v); chk("R4 done set", v & 1, 1);
    chk("R4 irq", irq, 1);
    chk("R6 no ack error", (v >> 2) & 1, 0);
    wr(0, 8'hA5);
    wr(1, EN | IEN | STO | GO);
    chk("R4 done cleared by go", irq, 0);
    @(posedge bus_scl); @(negedge bus_scl); ta = $realtime;
    @(posedge bus_scl); tb = $realtime;
    @(negedge bus_scl); tc = $realtime;
    chk("R10 low period D=3", int'(tb - ta), 40);
    chk("R10 high period D=3", int'(tc - tb), 40);
    wait_stat(8, 0);
    chk("R5 data byte", log_b[1], 8'hA5);
    chk("R5 stop seen", stops - p0, 1);
    rdr(2, v); chk("R5 done after stop", v & 9, 1);
    wr(2, 7);
  endtask

  task automatic t_nack();
    int v;
    wr(0, 8'h30);
    wr(1, EN | STA | STO | GO);
    wait_stat(9, 1);
    rdr(2, v); chk("R6 ack error", (v >> 2) & 1, 1);
    wr(2, 7);
    rdr(2, v); chk("R11 flags cleared", v & 7, 0);
  endtask

  task automatic t_read();
    int v;
    realtime ta, tb;
    rdbuf[1] = 8'hC3; rdbuf[2] = 8'h3C;
    wr(3, 1);
    wr(0, 8'h55);
    wr(1, EN | STA | GO);
    wait_stat(1, 1);
    rdr(2, v); chk("R7 receive mode", (v >> 5) & 1, 1);
    wr(1, EN | GO);
    @(posedge bus_scl); @(negedge bus_scl); ta = $realtime;
    @(posedge bus_scl); tb = $realtime;
    chk("R10 low period D=1", int'(tb - ta), 20);
    wait_stat(1, 1);
    rdr(0, v); chk("R7 first byte", v, 8'hC3);
    chk("R7 master ack", mack, 0);
    wr(1, EN | ACKN | STO | GO);
    wait_stat(9, 1);
    rdr(0, v); chk("R7 second byte", v, 8'h3C);
    chk("R7 master nack", mack, 1);
    wr(2, 7);
    wr(3, 3);
  endtask

  task automatic t_arb_data();
    int v;
    wr(0, 8'h54);
    wr(1, EN | STA | GO);
    wait_stat(1, 1);
    wr(0, 8'hFF);
    wr(1, EN | GO);
    repeat (3) @(negedge bus_scl);
    rogue = 1;
    @(negedge bus_scl);
    rogue = 0;
    wait_stat(8, 0);
    rdr(2, v);
    chk("R8 arbitration flag", (v >> 1) & 1, 1);
    chk("R8 done not set", v & 1, 0);
    rdr(1, v); chk("R8 go cleared", v & 1, 0);
    @(negedge clk); chk("R8 lines released", {scl_oe, sda_oe}, 0);
    rogue_stop();
    rdr(2, v); chk("R8 bus free", (v >> 4) & 1, 0);
    wr(2, 7);
  endtask

  task automatic t_arb_addr();
    int v, p0;
    log_b[0] = 0;
    wr(0, 8'h54);
    wr(1, EN | STA | STO | GO);
    @(negedge bus_sda);
    repeat (2) @(negedge bus_scl);
    rogue = 1;
    @(negedge bus_scl);
    rogue = 0;
    repeat (200) @(negedge clk);
    chk("R9 lines released while waiting", {scl_oe, sda_oe}, 0);
    rdr(1, v); chk("R9 go kept", v & 1, 1);
    rdr(2, v); chk("R9 arbitration flag", (v >> 1) & 1, 1);
    p0 = stops;
    rogue_stop();
    wait_stat(9, 1);
    chk("R9 address resent", log_b[0], 8'h54);
    rdr(2, v); chk("R9 acknowledged", (v >> 2) & 1, 0);
    chk("R9 stop after retry", stops - p0, 2);
  endtask

  initial begin
    log_b[0] = 0; log_b[1] = 0; log_b[2] = 0; log_b[3] = 0;
    rdbuf[0] = 0; rdbuf[1] = 0; rdbuf[2] = 0; rdbuf[3] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_disabled();
    t_write();
    t_nack();
    t_read();
    t_arb_data();
    t_arb_addr();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #900000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule